// File: doc/BRIEF.md
# Inter-Processor Interrupt Mailbox

This block lets each core of a small multiprocessor (one to four cores) interrupt another core and hand it a 16-bit message. Every core has a pair of 32-bit registers on a simple single-master register bus. The first is a control word, which the core writes to send or acknowledge. The second is a status word, which holds the message most recently delivered to that core. Each core has one interrupt line, and that line is high for as long as the core's status shows a message as pending.

Each core owns a one-entry mailbox. A second message sent to the same core replaces the first, whether or not the first was acknowledged. To send, a core writes its own control register with the send bit set, a destination core ID and a payload. To acknowledge, a core writes its own control register with the acknowledge bit set. Each bus request is accepted in one cycle, and the response follows in the next cycle.

Top module: `ipi_mailbox`

## Requirements
- R1: While reset is high and in the first cycle after it, every control and status register reads zero, every interrupt output is low and rsp_ready is low.
- R2: rsp_ready is high in exactly the cycle after each cycle in which req_valid is high, and low otherwise.
- R3: Byte address bit 2 selects the register: 0 selects control, 1 selects status. Address bits from bit 3 upward give the core index. Bits 1:0 are ignored. A write to a control register stores all 32 bits, and a later read returns the stored word unchanged.
- R4: A control write with bit 30 (send) set and a destination ID in bits 29:16 that is below NCORES overwrites that destination's status. The new status is bit 31 = 0, bit 30 = 1 (pending), bits 29:16 = the writer's core index and bits 15:0 = write data bits 15:0. The destination's interrupt output is high from the next cycle.
- R5: A control write with bit 31 (acknowledge) set clears bit 30 of the writer's own status and drops the writer's interrupt output in the next cycle. Status bits 29:0 are left unchanged.
- R6: When one control write sets both bit 31 and bit 30, the send takes effect before the acknowledge. A core that sends to itself in this way ends with the new sender ID and payload in its status and with pending clear.
- R7: A write to any status register changes no register and no interrupt output.
- R8: A send whose destination ID is NCORES or greater delivers nothing and changes no interrupt output. The writer's control register still stores the written word.
- R9: Each interrupt output always equals bit 30 of the same core's status register, and it changes only as the result of a control write.
- R10: An access to a core index of NCORES or greater changes nothing, and a read from such an index returns zero.
- R11: The mailbox holds a single entry: a later send to a core replaces the sender ID and payload of an earlier one, even if the earlier one is still pending.
- R12: rsp_rdata carries the addressed register's value in the cycle after a read request, and zero in the cycle after a write request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Register request present this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address within the register window |
| req_wdata | input | 32 | Write data |
| rsp_ready | output | 1 | Request completed (one cycle after req_valid) |
| rsp_rdata | output | 32 | Read data, valid while rsp_ready is high |
| irq_o | output | NCORES | Level interrupt per core |

## Verification
Delivery and acknowledge can both be triggered by a single control write, and they land on the same status register when a core names itself as the destination. The bench provokes this with directed self-targeted writes that carry both bits, and with random control words in which both bits and the destination ID are drawn freely. The result is judged by reading the writer's status back: it must hold the new sender and payload with pending clear, and its interrupt line must be low. A reference model applies the send first and the acknowledge second and is compared with the read-back value and the line after every write.

// File: rtl/ipi_mailbox_pkg.sv
package ipi_mailbox_pkg;
  localparam int WORD_W   = 32;
  localparam int ACK_BIT  = 31;
  localparam int SEND_BIT = 30;
  localparam int PEND_BIT = 30;
  localparam int ID_LSB   = 16;
  localparam int ID_W     = 14;
  localparam int MSG_W    = 16;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [ID_W-1:0]   core_id_t;
  typedef logic [MSG_W-1:0]  msg_t;

  // Build a freshly delivered status word: pending set, sender and payload.
  function automatic word_t pack_status(core_id_t sender, msg_t payload);
    word_t w;
    w = '0;
    w[PEND_BIT] = 1'b1;
    w[ID_LSB +: ID_W] = sender;
    w[MSG_W-1:0] = payload;
    return w;
  endfunction
endpackage

// File: rtl/ipi_decode.sv
module ipi_decode
  import ipi_mailbox_pkg::*;
#(
  parameter int NCORES = 4,
  parameter int ADDR_W = 8
) (
  input  logic                  req_valid,
  input  logic                  req_we,
  input  logic [ADDR_W-1:2]     req_word,
  input  word_t                 req_wdata,
  output logic [NCORES-1:0]     core_hit,
  output logic                  sel_status,
  output logic [NCORES-1:0]     ctrl_wr,
  output logic [NCORES-1:0]     send_hit,
  output logic [NCORES-1:0]     ack_hit,
  output core_id_t              sender_id
);
  localparam int IDX_W = ADDR_W - 3;

  logic [IDX_W-1:0] core_idx;
  core_id_t         dest_id;
  logic             idx_ok;
  logic             dest_ok;
  logic             any_ctrl_wr;

  assign core_idx   = req_word[ADDR_W-1:3];
  assign sel_status = req_word[2];
  assign dest_id    = req_wdata[ID_LSB +: ID_W];
  assign idx_ok     = int'(core_idx) < NCORES;
  assign dest_ok    = int'(dest_id) < NCORES;
  assign sender_id  = ID_W'(core_idx);
  assign any_ctrl_wr = |ctrl_wr;

  for (genvar i = 0; i < NCORES; i++) begin : g_core
    assign core_hit[i] = idx_ok && (core_idx == IDX_W'(i));
    assign ctrl_wr[i]  = req_valid && req_we && !sel_status && core_hit[i];
    assign send_hit[i] = any_ctrl_wr && req_wdata[SEND_BIT] && dest_ok &&
                         (dest_id == ID_W'(i));
    assign ack_hit[i]  = ctrl_wr[i] && req_wdata[ACK_BIT];
  end
endmodule

// File: rtl/ipi_core_slot.sv
module ipi_core_slot
  import ipi_mailbox_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     ctrl_wr,
  input  logic     send_hit,
  input  logic     ack_hit,
  input  core_id_t sender_id,
  input  word_t    wdata,
  output word_t    ctrl_q,
  output word_t    stat_q,
  output logic     irq
);
  word_t stat_d;

  // Delivery is applied first, then the acknowledge clears pending.
  always_comb begin
    stat_d = stat_q;
    if (send_hit) stat_d = pack_status(sender_id, wdata[MSG_W-1:0]);
    if (ack_hit)  stat_d[PEND_BIT] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      stat_q <= '0;
    end else begin
      if (ctrl_wr) ctrl_q <= wdata;
      stat_q <= stat_d;
    end
  end

  assign irq = stat_q[PEND_BIT];
endmodule

// File: rtl/ipi_readback.sv
module ipi_readback
  import ipi_mailbox_pkg::*;
#(
  parameter int NCORES = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    req_valid,
  input  logic                    req_we,
  input  logic [NCORES-1:0]       core_hit,
  input  logic                    sel_status,
  input  logic [NCORES-1:0][31:0] ctrl_all,
  input  logic [NCORES-1:0][31:0] stat_all,
  output logic                    rsp_ready,
  output word_t                   rsp_rdata
);
  word_t rd_mux;

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NCORES; i++) begin
      if (core_hit[i]) rd_mux = sel_status ? stat_all[i] : ctrl_all[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_ready <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_ready <= req_valid;
      rsp_rdata <= (req_valid && !req_we) ? rd_mux : '0;
    end
  end
endmodule

// File: rtl/ipi_mailbox.sv
module ipi_mailbox
  import ipi_mailbox_pkg::*;
#(
  parameter int NCORES = 4,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_ready,
  output logic [31:0]       rsp_rdata,
  output logic [NCORES-1:0] irq_o
);
  logic [NCORES-1:0]       core_hit;
  logic                    sel_status;
  logic [NCORES-1:0]       ctrl_wr;
  logic [NCORES-1:0]       send_hit;
  logic [NCORES-1:0]       ack_hit;
  core_id_t                sender_id;
  logic [NCORES-1:0][31:0] ctrl_all;
  logic [NCORES-1:0][31:0] stat_all;

  ipi_decode #(.NCORES(NCORES), .ADDR_W(ADDR_W)) u_decode (
    .req_valid (req_valid),
    .req_we    (req_we),
    .req_word  (req_addr[ADDR_W-1:2]),
    .req_wdata (req_wdata),
    .core_hit  (core_hit),
    .sel_status(sel_status),
    .ctrl_wr   (ctrl_wr),
    .send_hit  (send_hit),
    .ack_hit   (ack_hit),
    .sender_id (sender_id)
  );

  for (genvar i = 0; i < NCORES; i++) begin : g_slot
    ipi_core_slot u_slot (
      .clk      (clk),
      .rst      (rst),
      .ctrl_wr  (ctrl_wr[i]),
      .send_hit (send_hit[i]),
      .ack_hit  (ack_hit[i]),
      .sender_id(sender_id),
      .wdata    (req_wdata),
      .ctrl_q   (ctrl_all[i]),
      .stat_q   (stat_all[i]),
      .irq      (irq_o[i])
    );
  end

  ipi_readback #(.NCORES(NCORES)) u_readback (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_we    (req_we),
    .core_hit  (core_hit),
    .sel_status(sel_status),
    .ctrl_all  (ctrl_all),
    .stat_all  (stat_all),
    .rsp_ready (rsp_ready),
    .rsp_rdata (rsp_rdata)
  );
endmodule

// File: rtl/ipi_mailbox_chk.sv
module ipi_mailbox_chk #(
  parameter int NCORES = 4,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_we,
  input logic [ADDR_W-1:0] req_addr,
  input logic [31:0]       req_wdata,
  input logic              rsp_ready,
  input logic [31:0]       rsp_rdata,
  input logic [NCORES-1:0] irq_o
);
  logic ctrl_write;
  logic oor_access;
  assign ctrl_write = req_valid && req_we && !req_addr[2];
  assign oor_access = int'(req_addr[ADDR_W-1:3]) >= NCORES;

  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (irq_o == '0 && !rsp_ready && rsp_rdata == '0));

  p_ready_follows_r2: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_ready);

  p_ready_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_ready);

  p_write_rdata_zero_r12: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_we) |=> rsp_rdata == '0);

  p_status_write_inert_r7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_we && req_addr[2]) |=> $stable(irq_o));

  p_oor_inert_r10: assert property (@(posedge clk) disable iff (rst)
    (req_valid && oor_access) |=> $stable(irq_o));

  p_irq_only_on_ctrl_r9: assert property (@(posedge clk) disable iff (rst)
    !ctrl_write |=> $stable(irq_o));

  for (genvar i = 0; i < NCORES; i++) begin : g_line
    p_irq_rise_r4: assert property (@(posedge clk) disable iff (rst)
      $rose(irq_o[i]) |-> $past(ctrl_write && req_wdata[30] &&
                                int'(req_wdata[29:16]) == i));
    p_irq_fall_r5: assert property (@(posedge clk) disable iff (rst)
      $fell(irq_o[i]) |-> $past(ctrl_write && req_wdata[31] &&
                                int'(req_addr[ADDR_W-1:3]) == i));
  end
endmodule

bind ipi_mailbox ipi_mailbox_chk #(.NCORES(NCORES), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_we(req_we),
  .req_addr(req_addr), .req_wdata(req_wdata), .rsp_ready(rsp_ready),
  .rsp_rdata(rsp_rdata), .irq_o(irq_o)
);

// File: tb/ipi_mailbox_bench.sv
module ipi_mailbox_bench;
  localparam int NCORES = 4;
  localparam int ADDR_W = 8;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              req_valid = 1'b0;
  logic              req_we = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [31:0]       req_wdata = '0;
  logic              rsp_ready;
  logic [31:0]       rsp_rdata;
  logic [NCORES-1:0] irq_o;

  int n_checks = 0;
  int n_fail = 0;
  logic [31:0] ctrl_m [NCORES];
  logic [31:0] stat_m [NCORES];

  always #5 clk = ~clk;

  ipi_mailbox #(.NCORES(NCORES), .ADDR_W(ADDR_W)) u_ipi_mailbox (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_ready(rsp_ready),
    .rsp_rdata(rsp_rdata), .irq_o(irq_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(int core, bit st);
    if (core >= NCORES) return 32'h0;
    return st ? stat_m[core] : ctrl_m[core];
  endfunction

  // Reference: stores control, delivers first, then acknowledges.
  function automatic void mdl_write(int core, bit st, logic [31:0] d);
    int dst;
    if (core >= NCORES || st) return;
    ctrl_m[core] = d;
    dst = int'(d[29:16]);
    if (d[30] && dst < NCORES) stat_m[dst] = {2'b01, 14'(core), d[15:0]};
    if (d[31]) stat_m[core][30] = 1'b0;
  endfunction

  task automatic access(input bit we, input int core, input bit st,
                        input logic [31:0] d, input bit cmp, input string tag);
    logic [31:0] expv;
    expv = we ? 32'h0 : exp_read(core, st);
    @(negedge clk);
    req_valid = 1'b1;
    req_we    = we;
    req_addr  = ADDR_W'((core << 3) | (int'(st) << 2) | $urandom_range(0, 3));
    req_wdata = d;
    @(negedge clk);
    chk(rsp_ready === 1'b1, "R2 ready after request", 32'(rsp_ready), 32'h1);
    if (cmp) chk(rsp_rdata === expv, tag, rsp_rdata, expv);
    req_valid = 1'b0;
    req_we    = 1'b0;
    @(negedge clk);
    chk(rsp_ready === 1'b0, "R2 ready idle", 32'(rsp_ready), 32'h0);
    if (we) mdl_write(core, st, d);
  endtask

  task automatic chk_irq(input string tag);
    logic [NCORES-1:0] e;
    for (int i = 0; i < NCORES; i++) e[i] = stat_m[i][30];
    chk(irq_o === e, tag, 32'(irq_o), 32'(e));
  endtask

  task automatic sweep(input string tag);
    for (int c = 0; c < NCORES + 2; c++) begin
      access(1'b0, c, 1'b0, 32'h0, 1'b1, {tag, " R3 control"});
      access(1'b0, c, 1'b1, 32'h0, 1'b1, {tag, " R9 status"});
    end
    chk_irq({tag, " R9 line"});
  endtask

  function automatic logic [31:0] cw(bit ack, bit send, int dst, logic [15:0] msg);
    return {ack, send, 14'(dst), msg};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < NCORES; i++) begin ctrl_m[i] = '0; stat_m[i] = '0; end
    repeat (4) @(negedge clk);
    chk(irq_o === '0, "R1 irq in reset", 32'(irq_o), 32'h0);
    chk(rsp_ready === 1'b0, "R1 ready in reset", 32'(rsp_ready), 32'h0);
    rst = 1'b0;
    @(negedge clk);
    chk(irq_o === '0, "R1 irq after reset", 32'(irq_o), 32'h0);
    chk(rsp_ready === 1'b0, "R1 ready after reset", 32'(rsp_ready), 32'h0);
    sweep("R1 reset contents");

    // R3: full word stored and returned
    access(1'b1, 1, 1'b0, 32'h1234_ABCD, 1'b1, "R12 write rdata zero");
    access(1'b0, 1, 1'b0, 32'h0, 1'b1, "R3 control readback");
    // R4: delivery from core 0 to core 2
    access(1'b1, 0, 1'b0, cw(0, 1, 2, 16'hBEEF), 1'b0, "");
    chk(irq_o[2] === 1'b1, "R4 irq raised", 32'(irq_o), 32'h4);
    access(1'b0, 2, 1'b1, 32'h0, 1'b1, "R4 status contents");
    // R11: overwrite while pending
    access(1'b1, 3, 1'b0, cw(0, 1, 2, 16'h0101), 1'b0, "");
    access(1'b0, 2, 1'b1, 32'h0, 1'b1, "R11 overwrite");
    chk(stat_m[2] == 32'h4003_0101, "R11 model", stat_m[2], 32'h4003_0101);
    // R5: acknowledge keeps fields
    access(1'b1, 2, 1'b0, cw(1, 0, 0, 16'h0), 1'b0, "");
    chk(irq_o[2] === 1'b0, "R5 irq dropped", 32'(irq_o), 32'h0);
    access(1'b0, 2, 1'b1, 32'h0, 1'b1, "R5 fields kept");
    // R6: send-to-self with acknowledge
    access(1'b1, 1, 1'b0, cw(1, 1, 1, 16'h5A5A), 1'b0, "");
    chk(irq_o[1] === 1'b0, "R6 self ack line", 32'(irq_o), 32'h0);
    access(1'b0, 1, 1'b1, 32'h0, 1'b1, "R6 self ack status");
    // R6: send to other core plus own ack
    access(1'b1, 3, 1'b0, cw(0, 1, 3, 16'h7777), 1'b0, "");
    chk_irq("R4 self send line");
    access(1'b1, 3, 1'b0, cw(1, 1, 0, 16'h1111), 1'b0, "");
    chk_irq("R6 send and ack line");
    // R7: status writes inert
    access(1'b1, 0, 1'b1, 32'hFFFF_FFFF, 1'b0, "");
    chk_irq("R7 status write line");
    access(1'b0, 0, 1'b1, 32'h0, 1'b1, "R7 status unchanged");
    // R8: destination out of range
    access(1'b1, 2, 1'b0, cw(0, 1, 7, 16'hCAFE), 1'b0, "");
    chk_irq("R8 no delivery line");
    access(1'b0, 2, 1'b0, 32'h0, 1'b1, "R8 control stored");
    // R10: core index out of range
    access(1'b1, 5, 1'b0, cw(1, 1, 0, 16'hDEAD), 1'b0, "");
    chk_irq("R10 oor write line");
    access(1'b0, 5, 1'b0, 32'h0, 1'b1, "R10 oor read zero");
    sweep("R10 after oor");

    for (int k = 0; k < 600; k++) begin
      int core;
      bit st;
      bit we;
      logic [31:0] d;
      core = $urandom_range(0, NCORES + 1);
      st   = ($urandom_range(0, 5) == 0);
      we   = ($urandom_range(0, 2) != 0);
      d    = $urandom;
      d[29:16] = 14'($urandom_range(0, NCORES + 1));
      access(we, core, st, d, 1'b1, we ? "R12 random write" : "R3 random read");
      chk_irq("R6 random line");
    end
    sweep("R9 final");

    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule